// File: doc/BRIEF.md
# Externally Clocked Serial Shifter

This block is the shift engine of a synchronous serial port whose bit clock comes from outside the chip. The serial clock pin and the serial data input pin are brought into the system clock domain, where their edges are detected. A falling edge of the serial clock puts the next transmit bit on the serial data output. A rising edge samples the serial data input. Words move least significant bit first. The length of each word is chosen when the transfer starts: a full byte or only the low nibble. When a nibble is received, the upper half of the word is filled with zeros.

Software loads a single data buffer while the port is idle and then issues a start command. The buffer's content is shifted out. When the last bit has been captured, the received word replaces the buffer contents and a completion flag is raised. The block never drives the clock pin. A sticky error flag records any clock phase during a transfer that was shorter than the minimum pulse width. The minimum is four machine cycles of four system clocks each, so 16 system clocks with the default parameters.

Top module: `sio_ext_shifter`

## Requirements
- R1: After reset, busy, done and timing_err are 0, so_o is 1 and rd_data is 0.
- R2: A write (wr_en high) while idle loads wr_data into the buffer, and rd_data shows it on the next cycle. A write while busy leaves the buffer unchanged.
- R3: A start pulse while idle sets busy and clears done. A start pulse while busy does not restart the transfer or reset the bit count.
- R4: On each synchronised falling edge of sck_i during a transfer, so_o presents the next buffer bit, starting with bit 0. Whenever the block is not busy, so_o is 1.
- R5: In byte mode (mode8 = 1 at start), si_i is sampled on each rising edge of sck_i. After 8 rising edges, bit k of rd_data holds the value sampled on the (k+1)th rising edge.
- R6: In nibble mode (mode8 = 0 at start), only buffer bits 3:0 are sent. Four received bits go to rd_data[3:0], and rd_data[7:4] become 0.
- R7: On the rising edge that captures the final bit, done goes to 1 and busy goes to 0. done stays 1 until the next accepted start.
- R8: During a transfer, timing_err becomes 1 if a low phase, or a high phase between bits, lasts fewer than 16 system clocks. A phase of exactly 16 clocks does not set it. Once set, the flag stays 1 until reset.
- R9: sck_oe is always 0, so the clock pin is never driven.
- R10: The transfer length is fixed by mode8 at the start. Changing mode8 during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start command pulse |
| mode8 | input | 1 | 1 = byte transfer, 0 = nibble transfer (sampled at start) |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Buffer write data |
| rd_data | output | 8 | Data buffer contents |
| sck_i | input | 1 | External serial clock pin, idles high |
| sck_oe | output | 1 | Clock pin output enable, held low |
| si_i | input | 1 | Serial data input pin |
| so_o | output | 1 | Serial data output pin |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete flag |
| timing_err | output | 1 | Sticky short-phase flag |

## Verification
A pin change on sck_i or si_i passes through two synchroniser flops and one state register. Its effect on so_o, done, busy, rd_data or timing_err therefore appears after the third rising clock edge following the change. Register writes and start pulses take effect after one edge. The bench changes pins on falling clock edges and samples four clocks after each serial clock edge, which is well inside the 16-clock phase. Phase lengths are set by counting whole clock periods, so the 15-clock and 16-clock cases fall exactly on either side of the limit.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int SIO_DATA_W    = 8;
    localparam int SIO_NIB_W     = 4;
    localparam int SIO_CLK_PER_MC = 4;
    localparam int SIO_MIN_MC    = 4;
    localparam int SIO_SYNC_LEN  = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } sio_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } sio_edge_t;

    // Minimum phase length in system clocks
    function automatic int min_phase_clks(input int clk_per_mc, input int min_mc);
        return clk_per_mc * min_mc;
    endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int                 WIDTH   = 2,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= RST_VAL;
                    else     stage_q[0] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RST_VAL;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sio_edge_timer.sv
module sio_edge_timer
    import sio_pkg::*;
#(
    parameter int MIN_PHASE = 16,
    localparam int CNT_W    = $clog2(MIN_PHASE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl_i,
    output sio_edge_t        ev_o,
    output logic [CNT_W-1:0] phase_len_o
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(MIN_PHASE);

    logic             lvl_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d <= 1'b1;
            cnt_q <= SAT;
        end else begin
            lvl_d <= lvl_i;
            if (lvl_i != lvl_d)  cnt_q <= CNT_W'(1);
            else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        ev_o.fall = lvl_d & ~lvl_i;
        ev_o.rise = ~lvl_d & lvl_i;
    end

    // Length of the phase that the current edge terminates
    assign phase_len_o = cnt_q;
endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core
    import sio_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NIB_W     = 4,
    parameter int MIN_PHASE = 16,
    localparam int CNT_W    = $clog2(MIN_PHASE + 1),
    localparam int BC_W     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode8,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              si_s,
    input  sio_edge_t         ev,
    input  logic [CNT_W-1:0]  phase_len,
    output logic [DATA_W-1:0] rd_data,
    output logic              so_o,
    output logic              busy,
    output logic              done,
    output logic              timing_err,
    output logic              len8_q
);
    localparam logic [BC_W-1:0]  LAST_BYTE = BC_W'(DATA_W - 1);
    localparam logic [BC_W-1:0]  LAST_NIB  = BC_W'(NIB_W - 1);
    localparam logic [CNT_W-1:0] MIN_L     = CNT_W'(MIN_PHASE);

    sio_state_e        state_q;
    logic [DATA_W-1:0] buf_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [BC_W-1:0]   bit_q;
    logic              first_q;

    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] rx_word;
    logic              last_bit;
    logic              short_ph;

    always_comb begin
        rx_next = {si_s, rx_q[DATA_W-1:1]};
        if (len8_q) begin
            rx_word = rx_next;
        end else begin
            rx_word = '0;
            rx_word[NIB_W-1:0] = rx_next[DATA_W-1 -: NIB_W];
        end
        last_bit = (bit_q == (len8_q ? LAST_BYTE : LAST_NIB));
        short_ph = (phase_len < MIN_L);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            buf_q      <= '0;
            tx_q       <= '0;
            rx_q       <= '0;
            bit_q      <= '0;
            first_q    <= 1'b0;
            so_o       <= 1'b1;
            done       <= 1'b0;
            timing_err <= 1'b0;
            len8_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (wr_en) buf_q <= wr_data;
                    if (start) begin
                        state_q <= ST_XFER;
                        tx_q    <= buf_q;
                        rx_q    <= '0;
                        bit_q   <= '0;
                        first_q <= 1'b1;
                        done    <= 1'b0;
                        len8_q  <= mode8;
                    end
                end
                ST_XFER: begin
                    if (ev.fall) begin
                        so_o    <= tx_q[0];
                        tx_q    <= tx_q >> 1;
                        first_q <= 1'b0;
                        if (!first_q && short_ph) timing_err <= 1'b1;
                    end
                    if (ev.rise && !first_q) begin
                        rx_q  <= rx_next;
                        bit_q <= bit_q + 1'b1;
                        if (short_ph) timing_err <= 1'b1;
                        if (last_bit) begin
                            buf_q   <= rx_word;
                            done    <= 1'b1;
                            so_o    <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q == ST_XFER);
    assign rd_data = buf_q;
endmodule

// File: rtl/sio_ext_shifter.sv
module sio_ext_shifter
    import sio_pkg::*;
#(
    parameter int DATA_W     = SIO_DATA_W,
    parameter int NIB_W      = SIO_NIB_W,
    parameter int CLK_PER_MC = SIO_CLK_PER_MC,
    parameter int MIN_MC     = SIO_MIN_MC,
    parameter int SYNC_LEN   = SIO_SYNC_LEN,
    localparam int MIN_PHASE = min_phase_clks(CLK_PER_MC, MIN_MC),
    localparam int CNT_W     = $clog2(MIN_PHASE + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode8,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sck_i,
    output logic              sck_oe,
    input  logic              si_i,
    output logic              so_o,
    output logic              busy,
    output logic              done,
    output logic              timing_err
);
    logic [1:0]       pins_s;
    sio_edge_t        ev;
    logic [CNT_W-1:0] phase_len;
    logic             len8_q;

    // bit 1 = serial clock (idles high), bit 0 = serial data in
    sio_sync #(.WIDTH(2), .STAGES(SYNC_LEN), .RST_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({sck_i, si_i}),
        .q_o (pins_s)
    );

    sio_edge_timer #(.MIN_PHASE(MIN_PHASE)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .lvl_i       (pins_s[1]),
        .ev_o        (ev),
        .phase_len_o (phase_len)
    );

    sio_shift_core #(.DATA_W(DATA_W), .NIB_W(NIB_W), .MIN_PHASE(MIN_PHASE)) u_core (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mode8      (mode8),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .si_s       (pins_s[0]),
        .ev         (ev),
        .phase_len  (phase_len),
        .rd_data    (rd_data),
        .so_o       (so_o),
        .busy       (busy),
        .done       (done),
        .timing_err (timing_err),
        .len8_q     (len8_q)
    );

    // External clock only: the clock pin stays released
    assign sck_oe = 1'b0;
endmodule

// File: rtl/sio_ext_shifter_chk.sv
module sio_ext_shifter_chk #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              so_o,
    input logic              timing_err,
    input logic              len8_q,
    input logic [DATA_W-1:0] rd_data
);
    AST_IDLE_SO_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> so_o);                                                  // R4

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy);                                           // R7

    AST_BUF_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(rd_data));                      // R2

    AST_NIBBLE_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && !len8_q) |-> (rd_data[DATA_W-1:NIB_W] == '0));    // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(timing_err) |-> timing_err);                                // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(done) && !busy) |-> done);                                 // R7
endmodule

bind sio_ext_shifter sio_ext_shifter_chk #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .so_o       (so_o),
    .timing_err (timing_err),
    .len8_q     (len8_q),
    .rd_data    (rd_data)
);

// File: tb/tb_sio_ext_shifter.sv
module tb_sio_ext_shifter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       mode8 = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sck_i = 1'b1;
    logic       sck_oe;
    logic       si_i = 1'b0;
    logic       so_o;
    logic       busy;
    logic       done;
    logic       timing_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sio_ext_shifter dut (
        .clk(clk), .rst(rst), .start(start), .mode8(mode8),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sck_i(sck_i), .sck_oe(sck_oe), .si_i(si_i), .so_o(so_o),
        .busy(busy), .done(done), .timing_err(timing_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; wr_en = 1'b0; sck_i = 1'b1; si_i = 1'b0; mode8 = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_buf(input logic [7:0] v);
        wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start(input logic m8);
        mode8 = m8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    // Drives n serial bits; each low phase lo clocks, each high phase hi clocks.
    task automatic run_bits(input int n, input int first, input logic [7:0] si_word,
                            input int lo, input int hi, inout logic [7:0] so_word);
        for (int i = 0; i < n; i++) begin
            sck_i = 1'b0;
            si_i  = si_word[first + i];
            repeat (4) @(negedge clk);
            so_word[first + i] = so_o;
            repeat (lo - 4) @(negedge clk);
            sck_i = 1'b1;
            repeat (hi) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "timing_err", timing_err, 0);
        chk("R1", "so_o", so_o, 1);
        chk("R1", "rd_data", rd_data, 0);
        chk("R9", "sck_oe", sck_oe, 0);
    endtask

    task automatic t_write();
        do_reset();
        write_buf(8'hA5);
        chk("R2", "rd_data after write", rd_data, 8'hA5);
    endtask

    task automatic t_byte(input logic [7:0] txv, input logic [7:0] rxv);
        logic [7:0] sw = '0;
        do_reset();
        write_buf(txv);
        pulse_start(1'b1);
        chk("R3", "busy after start", busy, 1);
        chk("R4", "so_o idle before first fall", so_o, 1);
        run_bits(8, 0, rxv, 16, 16, sw);
        chk("R4", "so bit sequence", sw, txv);
        chk("R7", "done", done, 1);
        chk("R7", "busy", busy, 0);
        chk("R5", "rd_data byte", rd_data, rxv);
        chk("R8", "no err at 16-clock phases", timing_err, 0);
        chk("R4", "so_o high after transfer", so_o, 1);
        chk("R9", "sck_oe during use", sck_oe, 0);
    endtask

    task automatic t_nibble();
        logic [7:0] sw = '0;
        do_reset();
        write_buf(8'hB7);
        pulse_start(1'b0);
        run_bits(4, 0, 8'hFD, 16, 16, sw);
        chk("R6", "so low nibble", sw[3:0], 4'h7);
        chk("R6", "done after 4 bits", done, 1);
        chk("R6", "rd_data zero-filled nibble", rd_data, 8'h0D);
    endtask

    task automatic t_busy_ignores();
        logic [7:0] sw = '0;
        do_reset();
        write_buf(8'h5A);
        pulse_start(1'b1);
        mode8 = 1'b0;
        run_bits(4, 0, 8'hF0, 16, 16, sw);
        chk("R10", "busy after 4 bits with mode changed", busy, 1);
        chk("R10", "done after 4 bits with mode changed", done, 0);
        wr_data = 8'hFF; wr_en = 1'b1; start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2", "rd_data unchanged by write while busy", rd_data, 8'h5A);
        chk("R3", "still busy after start while busy", busy, 1);
        run_bits(4, 4, 8'hF0, 16, 16, sw);
        chk("R3", "done after 8 bits total", done, 1);
        chk("R5", "rd_data after byte", rd_data, 8'hF0);
        chk("R4", "so byte sequence", sw, 8'h5A);
        repeat (20) @(negedge clk);
        chk("R7", "done held while idle", done, 1);
        mode8 = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R7", "done cleared by start", done, 0);
        chk("R3", "busy after new start", busy, 1);
    endtask

    task automatic t_err(input int lo, input int hi, input int exp, input string what);
        logic [7:0] sw = '0;
        do_reset();
        write_buf(8'h33);
        pulse_start(1'b1);
        run_bits(8, 0, 8'hC3, lo, hi, sw);
        chk("R8", what, timing_err, exp);
        if (exp == 1) begin
            repeat (30) @(negedge clk);
            chk("R8", "error flag sticky", timing_err, 1);
        end
    endtask

    initial begin
        t_reset();
        t_write();
        t_byte(8'h3C, 8'h96);
        t_byte(8'hC1, 8'h2B);
        t_nibble();
        t_busy_ignores();
        t_err(15, 16, 1, "short low phase");
        t_err(16, 15, 1, "short high phase");
        t_err(16, 16, 0, "exact minimum phases");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule